// File: doc/BRIEF.md
# Serial/Parallel Nibble Entry Register

This block is the entry stage that sits in front of a fall-through FIFO stack that is one nibble wide. It collects one data word. The word arrives either as a single parallel load from a data bus or as a train of serial bits. The serial bits are captured on falling edges of a slow serial clock. That clock is sampled by the block's system clock through a synchronizer. The register holds the word and drives an active-low full flag until the stack takes the word.

The register does not count bits to learn that it is full. A single marker bit is preset at the top of a chain one bit longer than the data word. Each serial shift moves the marker one place down. When the marker drops out of the data bits into the last flip-flop, the word is complete and the flag goes low. A parallel load writes the same flip-flops and sets the marker in one step. When the stack acknowledges the word, the register goes back to its initial state.

Top module: `fifo_entry_reg`

## Requirements
- R1: A synchronous reset (`rstSync` high at a clock edge) leaves `nibble` = 4'b1000 and `fullN` = 1 after that edge. Reset takes priority over every other input.
- R2: `fullN` is 1 while the marker flip-flop is clear and 0 once the marker is set. Only a parallel load or the fourth serial shift can set the marker.
- R3: While `loadPar` is high at a clock edge, and no acknowledge of a full register occurs at that edge, `nibble` takes `parData` and `fullN` goes to 0 after that edge.
- R4: A serial shift happens only on a falling edge of `serClk`, and only while `serEnN` and `loadPar` are both low. A rising edge of `serClk` changes nothing. A shift takes effect within four system clock cycles of the falling edge.
- R5: A shift moves `serData` into `nibble[3]` and every other bit one place toward `nibble[0]`. After one shift from the initial state, `nibble` = {b0,1,0,0}. After four shifts, the first bit received sits in `nibble[0]`, the fourth sits in `nibble[3]`, and `fullN` = 0.
- R6: While `fullN` = 0, further `serClk` falling edges leave `nibble` and `fullN` unchanged until an acknowledge or a reset.
- R7: While `serEnN` = 1, falling edges of `serClk` leave `nibble` and `fullN` unchanged.
- R8: `ackTake` high at a clock edge while `fullN` = 0 returns the register to `nibble` = 4'b1000 and `fullN` = 1 after that edge.
- R9: `ackTake` while `fullN` = 1 has no effect. The register state is unchanged, and a parallel load at the same edge still takes place.
- R10: An acknowledge of a full register takes priority over a parallel load at the same edge. The result is the initial state.
- R11: A falling `serClk` edge seen while `loadPar` is high is not shifted. The loaded word stays in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstSync | input | 1 | Synchronous master reset, active high |
| loadPar | input | 1 | Parallel load strobe, active high |
| parData | input | 4 | Parallel data word |
| serData | input | 1 | Serial data bit |
| serClk | input | 1 | Serial clock; a shift occurs on its falling edge |
| serEnN | input | 1 | Serial input enable, active low |
| ackTake | input | 1 | Stack has taken the word |
| nibble | output | 4 | Held data word |
| fullN | output | 1 | Register full flag, active low |

## Verification
An acknowledge from the stack can fall in the same cycle as a parallel load. A falling serial clock edge can fall in the same cycle as a parallel load. The bench holds `ackTake` and `loadPar` high together on a full register and expects the initial state (R10). It also holds them together on an empty register and expects the loaded word (R9). It drops `serClk` while `loadPar` is held and expects the loaded word with no shift applied (R11). Reset is also driven together with both acknowledge and load, and the expected result is the reset state.

// File: rtl/fifo_entry_pkg.sv
package fifo_entry_pkg;
  typedef struct packed {
    logic init;
    logic load;
    logic shift;
  } entryStrobes_t;
endpackage

// File: rtl/ser_clk_edge.sv
module ser_clk_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstSync,
  input  logic serClk,
  output logic fallPulse
);
  localparam int PIPE_W = SYNC_STAGES + 1;
  logic [PIPE_W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rstSync) pipe <= '0;
    else         pipe <= {pipe[PIPE_W-2:0], serClk};
  end

  // previous sampled value high, current synchronized value low
  assign fallPulse = pipe[PIPE_W-1] & ~pipe[PIPE_W-2];
endmodule

// File: rtl/entry_ctrl.sv
module entry_ctrl
  import fifo_entry_pkg::*;
(
  input  logic          rstSync,
  input  logic          ackTake,
  input  logic          loadPar,
  input  logic          serEnN,
  input  logic          serFall,
  input  logic          markerFull,
  output entryStrobes_t strobes
);
  logic ackFull;
  assign ackFull = ackTake & markerFull;

  always_comb begin
    strobes = '0;
    if (rstSync || ackFull)             strobes.init  = 1'b1;
    else if (loadPar)                   strobes.load  = 1'b1;
    else if (serFall && !serEnN && !markerFull) strobes.shift = 1'b1;
  end
endmodule

// File: rtl/entry_datapath.sv
module entry_datapath
  import fifo_entry_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  entryStrobes_t     strobes,
  input  logic [DATA_W-1:0] parData,
  input  logic              serData,
  output logic [DATA_W-1:0] nibble,
  output logic              markerFull
);
  localparam int CHAIN_W = DATA_W + 1;
  localparam logic [CHAIN_W-1:0] CHAIN_INIT = {1'b1, {DATA_W{1'b0}}};

  // chain[0] is the marker, chain[i+1] is data bit i
  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (strobes.init)       chain <= CHAIN_INIT;
    else if (strobes.load)  chain <= {parData, 1'b1};
    else if (strobes.shift) chain <= {serData, chain[CHAIN_W-1:1]};
  end

  assign nibble     = chain[CHAIN_W-1:1];
  assign markerFull = chain[0];
endmodule

// File: rtl/fifo_entry_reg.sv
module fifo_entry_reg
  import fifo_entry_pkg::*;
#(
  parameter int DATA_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstSync,
  input  logic              loadPar,
  input  logic [DATA_W-1:0] parData,
  input  logic              serData,
  input  logic              serClk,
  input  logic              serEnN,
  input  logic              ackTake,
  output logic [DATA_W-1:0] nibble,
  output logic              fullN
);
  entryStrobes_t strobes;
  logic serFall;
  logic markerFull;

  ser_clk_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rstSync(rstSync), .serClk(serClk), .fallPulse(serFall)
  );

  entry_ctrl u_ctrl (
    .rstSync(rstSync), .ackTake(ackTake), .loadPar(loadPar),
    .serEnN(serEnN), .serFall(serFall), .markerFull(markerFull),
    .strobes(strobes)
  );

  entry_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .strobes(strobes), .parData(parData), .serData(serData),
    .nibble(nibble), .markerFull(markerFull)
  );

  assign fullN = ~markerFull;
endmodule

// File: rtl/fifo_entry_reg_chk.sv
module fifo_entry_reg_chk #(
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rstSync,
  input logic              loadPar,
  input logic [DATA_W-1:0] parData,
  input logic              serEnN,
  input logic              ackTake,
  input logic [DATA_W-1:0] nibble,
  input logic              fullN
);
  localparam logic [DATA_W-1:0] INIT_WORD = {1'b1, {(DATA_W-1){1'b0}}};
  logic rstQ;
  always_ff @(posedge clk) rstQ <= rstSync;

  // R1
  always @(negedge clk) begin
    if (rstQ) reset_state_chk: assert (nibble == INIT_WORD && fullN == 1'b1);
  end

  // R3
  parallel_load_chk: assert property (@(posedge clk) disable iff (rstSync)
    (loadPar && !(ackTake && !fullN)) |=> (nibble == $past(parData) && !fullN));

  // R6
  full_freeze_chk: assert property (@(posedge clk) disable iff (rstSync)
    (!fullN && !ackTake && !loadPar) |=> ($stable(nibble) && !fullN));

  // R7
  serial_inhibit_chk: assert property (@(posedge clk) disable iff (rstSync)
    (serEnN && !loadPar && !ackTake) |=> ($stable(nibble) && $stable(fullN)));

  // R8
  ack_release_chk: assert property (@(posedge clk) disable iff (rstSync)
    (ackTake && !fullN) |=> (nibble == INIT_WORD && fullN));
endmodule

bind fifo_entry_reg fifo_entry_reg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstSync(rstSync), .loadPar(loadPar), .parData(parData),
  .serEnN(serEnN), .ackTake(ackTake), .nibble(nibble), .fullN(fullN)
);

// File: tb/test_fifo_entry_reg.sv
module test_fifo_entry_reg;
  logic clk = 1'b0;
  logic rstSync = 1'b1, loadPar = 1'b0, serData = 1'b0, serClk = 1'b0;
  logic serEnN = 1'b0, ackTake = 1'b0;
  logic [3:0] parData = 4'h0;
  logic [3:0] nibble;
  logic fullN;
  int testsRun = 0, testsFailed = 0;
  bit done = 1'b0;

  localparam logic [4:0] INIT_STATE = 5'b1_1000; // {fullN, nibble}

  always #10 clk = ~clk;

  fifo_entry_reg i_fifo_entry_reg (
    .clk(clk), .rstSync(rstSync), .loadPar(loadPar), .parData(parData),
    .serData(serData), .serClk(serClk), .serEnN(serEnN), .ackTake(ackTake),
    .nibble(nibble), .fullN(fullN)
  );

  function automatic logic [4:0] expLoaded(input logic [3:0] d);
    return {1'b0, d};
  endfunction

  function automatic logic [4:0] expSerial(input logic [3:0] bits);
    // bits[0] arrives first and ends in nibble[0]
    return {1'b0, bits[3], bits[2], bits[1], bits[0]};
  endfunction

  task automatic check(input string req, input logic [4:0] exp);
    testsRun++;
    if ({fullN, nibble} !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %b expected %b", req, {fullN, nibble}, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic serBit(input logic b);
    serData = b; serClk = 1'b1; tick(4);
    serClk = 1'b0; tick(6);
  endtask

  task automatic doReset();
    rstSync = 1'b1; tick(2); rstSync = 1'b0; tick(1);
  endtask

  task automatic pulseAck();
    ackTake = 1'b1; tick(1); ackTake = 1'b0;
  endtask

  task automatic loadWord(input logic [3:0] d);
    parData = d; loadPar = 1'b1; tick(1); loadPar = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    tick(3);
    rstSync = 1'b0; tick(1);
    check("R1 reset state", INIT_STATE);

    // R4: rising edge alone does nothing
    serData = 1'b0; serClk = 1'b1; tick(8);
    check("R4 rising edge ignored", INIT_STATE);
    serClk = 1'b0; tick(6);
    check("R5 first shift", 5'b1_0100);
    serBit(1'b1);
    check("R5 second shift", 5'b1_1010);
    serBit(1'b1);
    check("R2 not full after three", 5'b1_1101);
    serBit(1'b0);
    check("R5 four bits placed", expSerial(4'b0110));
    serBit(1'b1);
    check("R6 fifth edge ignored", expSerial(4'b0110));

    pulseAck(); tick(1);
    check("R8 ack releases", INIT_STATE);

    // R9: ack while empty, plus load in same cycle
    pulseAck(); tick(1);
    check("R9 ack while empty ignored", INIT_STATE);
    parData = 4'h5; loadPar = 1'b1; ackTake = 1'b1; tick(1);
    loadPar = 1'b0; ackTake = 1'b0;
    check("R9 load beside idle ack", expLoaded(4'h5));

    // R10: ack of full word beats load
    parData = 4'hA; loadPar = 1'b1; ackTake = 1'b1; tick(1);
    loadPar = 1'b0; ackTake = 1'b0;
    check("R10 ack over load", INIT_STATE);

    // R1: reset beats ack and load
    loadWord(4'h3);
    rstSync = 1'b1; ackTake = 1'b1; parData = 4'hF; loadPar = 1'b1; tick(1);
    rstSync = 1'b0; ackTake = 1'b0; loadPar = 1'b0; tick(1);
    check("R1 reset over ack and load", INIT_STATE);

    // R7: disabled serial input
    serEnN = 1'b1;
    serBit(1'b1); serBit(1'b0);
    check("R7 enable high ignores edges", INIT_STATE);
    serEnN = 1'b0;

    // R11: falling edge during load is not shifted
    serData = 1'b0; serClk = 1'b1; tick(5);
    parData = 4'h9; loadPar = 1'b1; serClk = 1'b0; tick(8);
    loadPar = 1'b0; tick(2);
    check("R11 load masks shift", expLoaded(4'h9));
    pulseAck(); tick(1);

    // random mix
    for (int i = 0; i < 24; i++) begin
      logic [3:0] d;
      d = 4'($urandom());
      if ($urandom() % 2 == 0) begin
        loadWord(d); tick(1);
        check("R3 random parallel", expLoaded(d));
      end else begin
        for (int k = 0; k < 4; k++) serBit(d[k]);
        check("R5 random serial", expSerial(d));
      end
      if ($urandom() % 3 == 0) begin
        serBit(~d[0]);
        check("R6 random extra edge", {1'b0, d});
      end
      pulseAck(); tick(1);
      check("R8 random release", INIT_STATE);
    end

    doReset();
    check("R1 final reset", INIT_STATE);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule